// File: doc/BRIEF.md
# Button Interrupt and Status Reporter

This block sits between the per-channel press detectors of a capacitive or inductive touch front end and the chip's pins and host register port. At each sampling-window boundary it takes the detection result for every channel and drives one button output per channel. It also drives a single interrupt pin, and it keeps a small set of sticky status flags that the host reads and clears. Error events and, in raw-data mode, the completion of a sampling cycle also raise the interrupt.

The host sees two registers. A status register at offset 0x00 clears on read. A polarity register at offset 0x11 picks the active level of the interrupt pin. A mode request selects button mode or raw-data mode, and the change is applied at the next window boundary. In raw-data mode the button outputs stay inactive and the interrupt reports data-ready and errors instead.

Top module: `btn_irq_reporter`

## Requirements
- R1: The polarity register at offset 0x11 (bit 0) resets to 0, which makes the interrupt pin active low; writing 1 makes it active high. A read of 0x11 returns this bit in bit 0.
- R2: `btn_out` changes only on a clock edge where `win_end` is high. At that edge it takes the value of `det` (in button mode), visible from the following cycle.
- R3: A button output that is asserted stays asserted until the first window boundary at which its `det` bit is 0.
- R4: Status bit 0 (press flag) sets at a window boundary where the button outputs go from all-zero to non-zero. A handover between buttons while at least one is held does not set it again.
- R5: Reading offset 0x00 returns the status value from before the read in `reg_rdata` on the next cycle, and it clears all status bits. Other offsets read as zero, and `reg_rdata` holds its value between reads.
- R6: While any button output is asserted, the interrupt pin is at its active level without a gap, including across a handover from one button to another.
- R7: A pulse on `err_evt[i]` sets status bit 2+i and holds the interrupt active until a status read clears it.
- R8: In raw-data mode all button outputs are 0. A `raw_rdy` pulse sets status bit 1 (data ready) and activates the interrupt until it is cleared.
- R9: A change of `raw_req` takes effect only at the next window boundary. A `raw_rdy` pulse while the effective mode is button mode has no effect on status bit 1.
- R10: An event that arrives in the same cycle as a status read stays set after the read.
- R11: After reset, `btn_out` is 0, all status bits are 0, `reg_rdata` is 0 and the interrupt pin is high (inactive).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_end | input | 1 | Sampling-window boundary strobe |
| det | input | 4 | Per-channel press result, valid with `win_end` |
| raw_req | input | 1 | Requested mode: 1 = raw data, 0 = buttons |
| raw_rdy | input | 1 | Pulse: all channels' raw data available |
| err_evt | input | 3 | Error event pulses, one per error type |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| btn_out | output | 4 | Button output pins, active high |
| irq_pin | output | 1 | Interrupt pin, level set by the polarity register |

## Verification
Two cases are hard to reach: a handover, where one button output drops at the same boundary at which another rises, and a status read that lands in the same cycle as a new error or data-ready event. Directed sequences build the handover from overlapping `det` patterns across three boundaries. They then line up a status read with an error pulse and with a raw-ready pulse. A long random phase then mixes boundaries, releases, mode requests, reads and polarity writes, and a cycle model in the bench predicts each pin and each read value.

// File: rtl/btn_irq_pkg.sv
package btn_irq_pkg;
  localparam logic [7:0] ADDR_STATUS = 8'h00;
  localparam logic [7:0] ADDR_POL    = 8'h11;
  localparam int         ST_PRESS    = 0;
  localparam int         ST_READY    = 1;
  localparam int         ST_ERR_LSB  = 2;
endpackage

// File: rtl/btn_window_latch.sv
module btn_window_latch #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_end,
  input  logic [N_CH-1:0] det,
  input  logic            raw_req,
  output logic [N_CH-1:0] btn_q,
  output logic            raw_q,
  output logic            first_press
);
  logic [N_CH-1:0] btn_d;
  logic            raw_d;

  always_comb begin
    btn_d = btn_q;
    raw_d = raw_q;
    if (win_end) begin
      raw_d = raw_req;
      btn_d = raw_req ? '0 : det;
    end
  end

  assign first_press = win_end && (btn_d != '0) && (btn_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q <= '0;
      raw_q <= 1'b0;
    end else if (win_end) begin
      btn_q <= btn_d;
      raw_q <= raw_d;
    end
  end

  // R2: outputs frozen between boundaries
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(btn_q));
  // R9: mode only moves at a boundary
  a_r9_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(raw_q));
  // R8: raw mode keeps the pins idle
  a_r8_raw_idle: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q |-> (btn_q == '0));
endmodule

// File: rtl/status_sticky.sv
module status_sticky #(
  parameter int ST_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic            clr,
  output logic [ST_W-1:0] st_q
);
  logic [ST_W-1:0] st_d;

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    always_comb begin
      st_d[i] = st_q[i];
      if (clr)        st_d[i] = 1'b0;
      if (set_vec[i]) st_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  st_q[i] <= 1'b0;
      else if (clr || set_vec[i])  st_q[i] <= st_d[i];
    end

    // R10: a set in the read cycle survives the clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> st_q[i]);
    // R5: only a read removes a flag
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !clr) |=> st_q[i]);
  end
endmodule

// File: rtl/irq_polarity.sv
module irq_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_wr,
  input  logic pol_wbit,
  input  logic active,
  output logic pol_q,
  output logic irq_pin
);
  logic pol_d;

  always_comb begin
    pol_d = pol_q;
    if (pol_wr) pol_d = pol_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= 1'b0;
    else if (pol_wr) pol_q <= pol_d;
  end

  assign irq_pin = pol_q ? active : ~active;

  // R1: polarity moves only on a write
  a_r1_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_wr |=> $stable(pol_q));
endmodule

// File: rtl/btn_irq_reporter.sv
module btn_irq_reporter
  import btn_irq_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int N_ERR  = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_end,
  input  logic [N_CH-1:0]   det,
  input  logic              raw_req,
  input  logic              raw_rdy,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_CH-1:0]   btn_out,
  output logic              irq_pin
);
  localparam int ST_W = ST_ERR_LSB + N_ERR;

  logic            raw_q, first_press, st_clr, pol_wr, pol_q, irq_active;
  logic [ST_W-1:0] set_vec, st_q;
  logic [DATA_W-1:0] rdata_d;

  btn_window_latch #(.N_CH(N_CH)) u_win (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .det(det),
    .raw_req(raw_req), .btn_q(btn_out), .raw_q(raw_q),
    .first_press(first_press)
  );

  always_comb begin
    set_vec = '0;
    set_vec[ST_PRESS] = first_press;
    set_vec[ST_READY] = raw_rdy && raw_q;
    set_vec[ST_W-1:ST_ERR_LSB] = err_evt;
  end

  assign st_clr = reg_rd && (reg_addr == ADDR_W'(ADDR_STATUS));
  assign pol_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_POL));

  status_sticky #(.ST_W(ST_W)) u_st (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(st_clr), .st_q(st_q)
  );

  assign irq_active = (btn_out != '0) || st_q[ST_READY] ||
                      (st_q[ST_W-1:ST_ERR_LSB] != '0);

  irq_polarity u_irq (
    .clk(clk), .rst_n(rst_n), .pol_wr(pol_wr), .pol_wbit(reg_wdata[0]),
    .active(irq_active), .pol_q(pol_q), .irq_pin(irq_pin)
  );

  always_comb begin
    rdata_d = '0;
    if (reg_addr == ADDR_W'(ADDR_STATUS))   rdata_d = DATA_W'(st_q);
    else if (reg_addr == ADDR_W'(ADDR_POL)) rdata_d = DATA_W'(pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rdata_d;
  end

  // R6: any held button keeps the pin active
  a_r6_irq_with_button: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_out != '0) |-> (irq_pin == pol_q));
  // R7: an error activates the interrupt on the next cycle
  a_r7_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_evt != '0) && !pol_wr) |=> (irq_pin == pol_q));
endmodule

// File: tb/btn_irq_reporter_test.sv
module btn_irq_reporter_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, win_end, raw_req, raw_rdy, reg_wr, reg_rd;
  logic [3:0] det;
  logic [2:0] err;
  logic [7:0] addr, wdata;
  logic [7:0] rdata;
  logic [3:0] btn_out;
  logic       irq_pin;

  int checks = 0;
  int fails  = 0;

  logic [3:0] m_btn;
  logic       m_raw, m_pol, rd_last;
  logic [4:0] m_st;
  logic [7:0] m_rd;

  always #(CLK_P/2) clk = ~clk;

  btn_irq_reporter uut (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .det(det), .raw_req(raw_req),
    .raw_rdy(raw_rdy), .err_evt(err), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .btn_out(btn_out), .irq_pin(irq_pin)
  );

  function automatic logic exp_pin();
    logic act;
    act = (m_btn != 4'b0) || m_st[1] || (m_st[4:2] != 3'b0);
    return m_pol ? act : ~act;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    win_end = 0; det = 0; raw_rdy = 0; err = 0;
    reg_wr = 0; reg_rd = 0; addr = 0; wdata = 0;
  endtask

  task automatic tick();
    logic [4:0] setv;
    logic [3:0] nb;
    @(posedge clk);
    setv = 5'b0;
    setv[4:2] = err;
    setv[1] = raw_rdy & m_raw;
    if (reg_rd)
      m_rd = (addr == 8'h00) ? {3'b0, m_st} : (addr == 8'h11) ? {7'b0, m_pol} : 8'h00;
    if (win_end) begin
      nb = raw_req ? 4'b0 : det;
      if (nb != 4'b0 && m_btn == 4'b0) setv[0] = 1'b1;
      m_btn = nb;
      m_raw = raw_req;
    end
    m_st = ((reg_rd && addr == 8'h00) ? 5'b0 : m_st) | setv;
    if (reg_wr && addr == 8'h11) m_pol = wdata[0];
    rd_last = reg_rd;
    @(negedge clk);
    chk("R2", {4'b0, btn_out}, {4'b0, m_btn});
    chk("R6", {7'b0, irq_pin}, {7'b0, exp_pin()});
    if (rd_last) chk("R5", rdata, m_rd);
  endtask

  task automatic boundary(logic [3:0] d);
    idle(); win_end = 1; det = d; tick(); idle();
  endtask

  task automatic rd(logic [7:0] a);
    idle(); reg_rd = 1; addr = a; tick(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    idle(); raw_req = 0; rst_n = 0;
    m_btn = 0; m_raw = 0; m_pol = 0; m_st = 0; m_rd = 0; rd_last = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", {4'b0, btn_out}, 8'h00);
    chk("R11", {7'b0, irq_pin}, 8'h01);
    chk("R11", rdata, 8'h00);
    rst_n = 1;
    tick();

    // R4 / R6: first press, handover, release
    boundary(4'b0001);
    chk("R4", {4'b0, btn_out}, 8'h01);
    chk("R6", {7'b0, irq_pin}, 8'h00);
    rd(8'h00);
    chk("R4", rdata, 8'h01);
    boundary(4'b0011);
    boundary(4'b0010);
    chk("R6", {7'b0, irq_pin}, 8'h00);
    rd(8'h00);
    chk("R4", rdata, 8'h00);
    idle(); tick();
    chk("R3", {4'b0, btn_out}, 8'h02);
    boundary(4'b0000);
    chk("R3", {4'b0, btn_out}, 8'h00);
    chk("R6", {7'b0, irq_pin}, 8'h01);

    // R7: error sets flag and interrupt until read
    idle(); err = 3'b010; tick(); idle();
    chk("R7", {7'b0, irq_pin}, 8'h00);
    rd(8'h00);
    chk("R7", rdata, 8'h08);
    chk("R7", {7'b0, irq_pin}, 8'h01);

    // R10: error coinciding with a status read
    idle(); reg_rd = 1; addr = 8'h00; err = 3'b001; tick(); idle();
    chk("R10", rdata, 8'h00);
    rd(8'h00);
    chk("R10", rdata, 8'h04);

    // R1: polarity
    rd(8'h11);
    chk("R1", rdata, 8'h00);
    idle(); reg_wr = 1; addr = 8'h11; wdata = 8'h01; tick(); idle();
    chk("R1", {7'b0, irq_pin}, 8'h00);
    rd(8'h11);
    chk("R1", rdata, 8'h01);

    // R9: mode request pending, raw_rdy ignored in button mode
    raw_req = 1;
    idle(); raw_rdy = 1; tick(); idle();
    rd(8'h00);
    chk("R9", rdata, 8'h00);
    // R8: raw mode idles the pins, data ready raises interrupt
    boundary(4'b1111);
    chk("R8", {4'b0, btn_out}, 8'h00);
    idle(); raw_rdy = 1; tick(); idle();
    chk("R8", {7'b0, irq_pin}, 8'h01);
    idle(); reg_rd = 1; addr = 8'h00; raw_rdy = 1; tick(); idle();
    chk("R8", rdata, 8'h02);
    chk("R10", {7'b0, irq_pin}, 8'h01);
    rd(8'h00);
    chk("R8", rdata, 8'h02);
    raw_req = 0;
    boundary(4'b0100);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      idle();
      win_end = ($urandom % 4) == 0;
      det     = (($urandom % 3) == 0) ? 4'b0 : 4'($urandom);
      err     = (($urandom % 16) == 0) ? 3'($urandom) : 3'b0;
      raw_rdy = ($urandom % 5) == 0;
      if (($urandom % 60) == 0) raw_req = ~raw_req;
      if (($urandom % 6) == 0) begin
        reg_rd = 1;
        case ($urandom % 3)
          0: addr = 8'h00;
          1: addr = 8'h11;
          default: addr = 8'h22;
        endcase
      end else if (($urandom % 40) == 0) begin
        reg_wr = 1; addr = 8'h11; wdata = 8'($urandom);
      end
      tick();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule